// File: doc/BRIEF.md
# Successive-Approximation Oscillator Frequency Search

This controller runs in the reference clock domain. It sets the control word of a digitally controlled oscillator quickly, before a proportional-integral phase-tracking loop takes over. A start strobe begins a two-cycle alignment search. That search picks a small extra delay for the reference clock so that the divided oscillator edge lines up with the reference edge. A ten-cycle binary search of the oscillator control word follows. Each cycle of either search settles one bit, most significant bit first. The decision for that bit is the early/late output of a bang-bang phase detector, sampled in the same cycle.

When the last oscillator bit is settled, a one-cycle completion pulse fires. A level handover signal then tells the proportional-integral loop that it owns the oscillator from here on. A configuration input chooses whether that loop is fed the plain reference or the delayed reference. The oscillator, the divider and the detector sit outside the block.

Top module: `sar_freq_search`

## Requirements
- R1: While reset is held, and just after it is released, both codes are zero and the completion, handover and delayed-reference select outputs are low.
- R2: The cycle after a start strobe is sampled, the delay code reads binary 10 and the oscillator code reads mid-scale, 0x200 (bit 9 only). Completion and handover are low.
- R3: The delay code is settled in the 2 cycles that follow the start. Bit 1 is decided first, then bit 0. A trial bit is kept when the detector input is 1 in that cycle and cleared when it is 0.
- R4: The oscillator code is settled in the 10 cycles after the delay search, bit 9 first down to bit 0, with the same keep-on-1 and clear-on-0 rule. With a detector that reports 1 whenever code <= target, the final code equals the target.
- R5: When a bit is decided, the next lower bit is set to 1 as its trial value in the same update. All bits below it stay 0.
- R6: The completion output is high for exactly one cycle, 12 cycles after the start strobe's edge, and handover rises in that same cycle.
- R7: After completion, and until the next start, both codes stay constant whatever the detector input does. Handover stays high over that span.
- R8: A start strobe that arrives during a search abandons it and begins a full new search from the R2 state. No completion pulse comes from the abandoned search.
- R9: Before any start, the detector input has no effect: the codes stay zero and handover stays low.
- R10: The delayed-reference select output equals the configuration input while handover is high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Begins (or restarts) a search |
| upIn | input | 1 | Bang-bang detector decision, 1 = oscillator too slow |
| useDelayedRef | input | 1 | Chooses the delayed reference for the tracking loop |
| delayCode | output | 2 | Reference delay selection |
| dcoCode | output | 10 | Oscillator control word |
| searchDone | output | 1 | One-cycle completion pulse |
| handover | output | 1 | Tracking loop owns the oscillator |
| refSelDelayed | output | 1 | Delayed reference selected for the tracking loop |

## Verification
The bench runs searches toward the extreme targets 0 and 1023, toward mid-scale, and toward alternating-bit patterns. A design that left the trial bit set on a 0 decision, or settled bits in the wrong order, would miss these targets. It checks the partial code after the first oscillator decision, which catches a trial bit that is set late or in the wrong position. It counts the exact cycle of the completion pulse, which would expose a search that spends an extra cycle or skips the delay phase. It then drives the detector input while the block is idle and again after completion. A block that still reacted there, or that kept the old search running when a restart arrived mid-search, would show altered codes or a stray pulse.

// File: rtl/sarfs_pkg.sv
package sarfs_pkg;
  // width of the bit index carried in the strobe bundle
  localparam int IDX_BITS = 8;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DELAY = 2'd1,
    PH_FREQ  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  typedef struct packed {
    logic                clearAll;
    logic                dlyStep;
    logic                dcoStep;
    logic [IDX_BITS-1:0] bitIdx;
  } strobe_t;
endpackage

// File: rtl/sarfs_ctrl.sv
module sarfs_ctrl
  import sarfs_pkg::*;
#(
  parameter int DCO_W = 10,
  parameter int DLY_W = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  output strobe_t strobes,
  output logic    doneQ,
  output logic    handQ
);
  localparam int MAXW = (DCO_W > DLY_W) ? DCO_W : DLY_W;
  localparam int IW   = (MAXW > 1) ? $clog2(MAXW) : 1;

  phase_t        phase;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      idx   <= '0;
      doneQ <= 1'b0;
      handQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (startPulse) begin
        phase <= PH_DELAY;
        idx   <= IW'(DLY_W - 1);
        handQ <= 1'b0;
      end else begin
        case (phase)
          PH_DELAY: begin
            if (idx == '0) begin
              phase <= PH_FREQ;
              idx   <= IW'(DCO_W - 1);
            end else begin
              idx <= idx - 1'b1;
            end
          end
          PH_FREQ: begin
            if (idx == '0) begin
              phase <= PH_HOLD;
              doneQ <= 1'b1;
              handQ <= 1'b1;
            end else begin
              idx <= idx - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strobes.clearAll = startPulse;
    strobes.dlyStep  = !startPulse && (phase == PH_DELAY);
    strobes.dcoStep  = !startPulse && (phase == PH_FREQ);
    strobes.bitIdx   = IDX_BITS'(idx);
  end
endmodule

// File: rtl/sarfs_sar_reg.sv
module sarfs_sar_reg
  import sarfs_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearAll,
  input  logic                step,
  input  logic [IDX_BITS-1:0] bitIdx,
  input  logic                upIn,
  output logic [W-1:0]        code
);
  // one register per bit: decided bit takes the detector vote,
  // the bit just below it becomes the next trial
  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam logic [IDX_BITS-1:0] POS     = IDX_BITS'(b);
    localparam logic [IDX_BITS-1:0] POS_ABV = IDX_BITS'(b + 1);
    localparam logic                MID_BIT = (b == W - 1);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        code[b] <= 1'b0;
      end else if (clearAll) begin
        code[b] <= MID_BIT;
      end else if (step) begin
        if (bitIdx == POS) begin
          code[b] <= upIn;
        end else if (bitIdx == POS_ABV) begin
          code[b] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_freq_search.sv
module sar_freq_search
  import sarfs_pkg::*;
#(
  parameter int DCO_W = 10,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             upIn,
  input  logic             useDelayedRef,
  output logic [DLY_W-1:0] delayCode,
  output logic [DCO_W-1:0] dcoCode,
  output logic             searchDone,
  output logic             handover,
  output logic             refSelDelayed
);
  strobe_t strobes;

  sarfs_ctrl #(.DCO_W(DCO_W), .DLY_W(DLY_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .strobes    (strobes),
    .doneQ      (searchDone),
    .handQ      (handover)
  );

  sarfs_sar_reg #(.W(DLY_W)) u_dly (
    .clk      (clk),
    .rstN     (rstN),
    .clearAll (strobes.clearAll),
    .step     (strobes.dlyStep),
    .bitIdx   (strobes.bitIdx),
    .upIn     (upIn),
    .code     (delayCode)
  );

  sarfs_sar_reg #(.W(DCO_W)) u_dco (
    .clk      (clk),
    .rstN     (rstN),
    .clearAll (strobes.clearAll),
    .step     (strobes.dcoStep),
    .bitIdx   (strobes.bitIdx),
    .upIn     (upIn),
    .code     (dcoCode)
  );

  assign refSelDelayed = handover & useDelayedRef;
endmodule

// File: rtl/sar_freq_search_chk.sv
module sar_freq_search_chk #(
  parameter int DCO_W = 10,
  parameter int DLY_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [DLY_W-1:0] delayCode,
  input logic [DCO_W-1:0] dcoCode,
  input logic             searchDone,
  input logic             handover,
  input logic             refSelDelayed
);
  localparam logic [DCO_W-1:0] DCO_MID = {1'b1, {(DCO_W-1){1'b0}}};
  localparam logic [DLY_W-1:0] DLY_MID = {1'b1, {(DLY_W-1){1'b0}}};

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    searchDone |=> !searchDone);

  // R6
  done_with_hand_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(handover) |-> searchDone);

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (dcoCode == DCO_MID && delayCode == DLY_MID && !handover && !searchDone));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (handover && !startPulse) |=> ($stable(dcoCode) && $stable(delayCode) && handover));

  // R10
  ref_sel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    refSelDelayed |-> handover);
endmodule

bind sar_freq_search sar_freq_search_chk #(.DCO_W(DCO_W), .DLY_W(DLY_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .startPulse    (startPulse),
  .delayCode     (delayCode),
  .dcoCode       (dcoCode),
  .searchDone    (searchDone),
  .handover      (handover),
  .refSelDelayed (refSelDelayed)
);

// File: tb/sim_sar_freq_search.sv
module sim_sar_freq_search;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic       upIn = 1'b0;
  logic       useDelayedRef = 1'b0;
  logic [1:0] delayCode;
  logic [9:0] dcoCode;
  logic       searchDone;
  logic       handover;
  logic       refSelDelayed;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  always #2.5ns clk = ~clk;

  sar_freq_search u0 (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .upIn          (upIn),
    .useDelayedRef (useDelayedRef),
    .delayCode     (delayCode),
    .dcoCode       (dcoCode),
    .searchDone    (searchDone),
    .handover      (handover),
    .refSelDelayed (refSelDelayed)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dcoCode == 0 && delayCode == 0, "R1 codes in reset", int'(dcoCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(dcoCode == 0 && delayCode == 0, "R1 codes after reset", int'(dcoCode), 0);
    chk(!searchDone && !handover && !refSelDelayed, "R1 flags after reset",
        int'({searchDone, handover, refSelDelayed}), 0);
  endtask

  // R9: detector toggles with no start issued
  task automatic t_idle_ignore();
    bit bad = 1'b0;
    useDelayedRef = 1'b1;
    for (int i = 0; i < 6; i++) begin
      upIn = i[0];
      @(posedge clk);
      @(negedge clk);
      if (dcoCode != 0 || delayCode != 0 || handover || refSelDelayed) bad = 1'b1;
    end
    chk(!bad, "R9 idle ignores detector", int'(dcoCode), 0);
  endtask

  task automatic pulse_start();
    startPulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic t_search(input int dT, input int target, input bit cfg);
    bit earlyDone = 1'b0;
    int partial;
    useDelayedRef = cfg;
    pulse_start();
    chk(dcoCode == 10'h200 && delayCode == 2'b10, "R2 start load", int'(dcoCode), 512);
    chk(!searchDone && !handover, "R2 flags cleared", int'(handover), 0);
    for (int k = 0; k < 12; k++) begin
      if (searchDone) earlyDone = 1'b1;
      if (k == 2) chk(int'(delayCode) == dT, "R3 delay result", int'(delayCode), dT);
      if (k == 3) begin
        partial = ((target >= 512) ? 512 : 0) | 256;
        chk(int'(dcoCode) == partial, "R5 trial after first decision", int'(dcoCode), partial);
      end
      if (k < 2) upIn = (int'(delayCode) <= dT);
      else       upIn = (int'(dcoCode) <= target);
      @(posedge clk);
      @(negedge clk);
    end
    chk(!earlyDone, "R6 no early done", int'(earlyDone), 0);
    chk(searchDone && handover, "R6 done at cycle 12", int'({searchDone, handover}), 3);
    chk(int'(dcoCode) == target, "R4 final code", int'(dcoCode), target);
    chk(refSelDelayed == cfg, "R10 ref select", int'(refSelDelayed), int'(cfg));
    for (int i = 0; i < 4; i++) begin
      upIn = ~upIn;
      @(posedge clk);
      @(negedge clk);
      if (i == 0) chk(!searchDone, "R6 done single cycle", int'(searchDone), 0);
    end
    chk(int'(dcoCode) == target && int'(delayCode) == dT && handover,
        "R7 hold stable", int'(dcoCode), target);
  endtask

  // R8: abandon a search midway
  task automatic t_restart();
    bit strayDone = 1'b0;
    pulse_start();
    for (int k = 0; k < 6; k++) begin
      upIn = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (searchDone) strayDone = 1'b1;
    end
    chk(!strayDone && !handover, "R8 no done before restart", int'(handover), 0);
    t_search(1, 700, 1'b1);
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_search(3, 1023, 1'b1);
    t_search(0, 0, 1'b0);
    t_search(2, 512, 1'b1);
    t_search(1, 341, 1'b0);
    t_search(2, 1, 1'b1);
    t_restart();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule